// File: doc/BRIEF.md
# Hub Time-Slot Arbiter with Slot Donation

Eight processor cores share one hub port. The arbiter walks a fixed rotation, one slot per clock, and each core owns one slot per eight-clock round. In every cycle it asserts at most one one-hot grant and a two-bit reason code that tells whether the slot went to its owner, to a donation target, or to a hungry core as a spare slot.

A core can name a target core and a donation rate. The rate can force some of its slots to the target at a fixed cadence, pass on only the slots it leaves unused, or, in submissive form, let the target claim the slot first. Cores that opt into hungry mode may pick up slots that nobody with a prior claim is using. A round-robin pointer shares these spare slots among several hungry requesters. One chip-wide input turns all spare-slot reuse off for testing. No core ever loses a slot it is entitled to and is requesting.

The claim order for each slot is fixed: a forced or submissive target first, then the owner, then a plain donation target, then the hungry cores. A target that is not requesting passes the slot down this order.

Top module: `hub_slot_arbiter`

## Requirements
- R1: After reset `slot_o` is 0. It advances by one every clock, wrapping from 7 to 0, whether or not the slot is used.
- R2: With donation rate 00 (no donation), a requesting slot owner is granted its slot and `why_o` is 01 (owner).
- R3: At most one bit of `grant_o` is set per clock. When no eligible core requests, `grant_o` is 0 and `why_o` is 00 (none).
- R4: A hungry core never receives a slot whose owner is requesting and has not given that slot away by forced or submissive donation.
- R5: A spare slot (`why_o` 11) goes only to a core that requests and whose `hungry_en_i` bit is 1. Cores with the bit at 0 never receive spare slots.
- R6: While `hungry_off_i` is 1, no spare slot is granted. A slot left unclaimed by the owner and the donation target gets no grant.
- R7: When several hungry cores request the same spare slot, a rotating pointer picks the first requester at or after it. The pointer then moves to the core just after the winner.
- R8: Rate 11 with the submissive bit at 0: when the owner is idle and the target requests, the target gets the slot with `why_o` 10 (donation).
- R9: Rate 11 with the submissive bit at 1: the target gets the slot whenever it requests, with `why_o` 10. The owner gets the slot only if the target is idle.
- R10: Rate 01: each core counts its own slots as occurrences 1 to 4, repeating, with occurrence 1 being its first slot after reset. Occurrences 2 and 4 go to a requesting target. Occurrences 1 and 3 stay with a requesting owner.
- R11: Rate 10: occurrences 2, 3 and 4 go to a requesting target. Occurrence 1 stays with a requesting owner.
- R12: When a forced or submissive target is idle, the slot falls to the owner. If the owner is idle too, it falls to the hungry cores. A target equal to the owner itself is treated as no donation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Per-core request for the hub port |
| hungry_en_i | input | 8 | Per-core opt-in for spare slots |
| hungry_off_i | input | 1 | Chip-wide disable of spare-slot reuse |
| don_tgt_i | input | 24 | Per-core donation target; core i uses bits [3i+2:3i] |
| don_rate_i | input | 16 | Per-core donation rate; core i uses bits [2i+1:2i] |
| don_sub_i | input | 8 | Per-core submissive flag, used with rate 11 |
| grant_o | output | 8 | One-hot grant for the current slot |
| why_o | output | 2 | Reason: 00 none, 01 owner, 10 donation, 11 spare |
| slot_o | output | 3 | Owner index of the current slot |

## Verification
The bench goes after the occurrence cadence of the forced rates. A per-owner counter that is off by one would hand slots 1 and 3 to the target instead of 2 and 4, or would leave slot 1 unprotected under rate 10. It drives owner and target requesting together under each rate, so a claim order that checks the owner before a submissive target, or a hungry core before the owner, shows up as a wrong core or a wrong reason. Several hungry cores request at once to expose a pointer that does not move past its winner, which would starve one core. Disabled-hungry and idle-target cases show whether a slot leaks to a core with no claim on it.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;
  typedef enum logic [1:0] {
    WHY_NONE   = 2'b00,
    WHY_OWNER  = 2'b01,
    WHY_DONATE = 2'b10,
    WHY_SPARE  = 2'b11
  } why_e;

  localparam logic [1:0] RATE_OFF   = 2'b00;
  localparam logic [1:0] RATE_HALF  = 2'b01;
  localparam logic [1:0] RATE_3Q    = 2'b10;
  localparam logic [1:0] RATE_IDLE  = 2'b11;
endpackage

// File: rtl/hub_slot_seq.sv
module hub_slot_seq #(
  parameter int N_CORES = 8,
  parameter int IDX_W   = $clog2(N_CORES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] slot_q,
  output logic [1:0]       occ
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CORES - 1);

  logic [IDX_W-1:0] slot_d;
  logic [1:0]       ord_q [N_CORES];
  logic [1:0]       ord_d [N_CORES];

  always_comb begin
    slot_d = (slot_q == LAST) ? '0 : slot_q + 1'b1;
    for (int i = 0; i < N_CORES; i++) begin
      ord_d[i] = ord_q[i];
      if (slot_q == IDX_W'(i)) ord_d[i] = ord_q[i] + 2'd1;
    end
  end

  assign occ = ord_q[slot_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      for (int i = 0; i < N_CORES; i++) ord_q[i] <= '0;
    end else begin
      slot_q <= slot_d;
      for (int i = 0; i < N_CORES; i++) ord_q[i] <= ord_d[i];
    end
  end
endmodule

// File: rtl/hub_slot_claim.sv
module hub_slot_claim
  import hub_arb_pkg::*;
#(
  parameter int N_CORES = 8,
  parameter int IDX_W   = $clog2(N_CORES)
) (
  input  logic [IDX_W-1:0]         owner,
  input  logic [1:0]               occ,
  input  logic [N_CORES-1:0]       req,
  input  logic [N_CORES*IDX_W-1:0] tgt_flat,
  input  logic [N_CORES*2-1:0]     rate_flat,
  input  logic [N_CORES-1:0]       sub,
  output logic [N_CORES-1:0]       pick_oh,
  output why_e                     pick_why,
  output logic                     spare_stage
);
  logic [IDX_W-1:0] tgt;
  logic [1:0]       rate;
  logic             self_tgt, forced, first_claim, plain_claim;

  always_comb begin
    tgt         = tgt_flat[int'(owner)*IDX_W +: IDX_W];
    rate        = rate_flat[int'(owner)*2 +: 2];
    self_tgt    = (tgt == owner);
    forced      = !self_tgt && (((rate == RATE_HALF) && occ[0]) ||
                                ((rate == RATE_3Q) && (occ != 2'd0)));
    first_claim = forced || (!self_tgt && (rate == RATE_IDLE) && sub[owner]);
    plain_claim = !self_tgt && (rate == RATE_IDLE) && !sub[owner];

    pick_oh     = '0;
    pick_why    = WHY_NONE;
    spare_stage = 1'b0;
    if (first_claim && req[tgt]) begin
      pick_oh[tgt] = 1'b1;
      pick_why     = WHY_DONATE;
    end else if (req[owner]) begin
      pick_oh[owner] = 1'b1;
      pick_why       = WHY_OWNER;
    end else if (plain_claim && req[tgt]) begin
      pick_oh[tgt] = 1'b1;
      pick_why     = WHY_DONATE;
    end else begin
      spare_stage = 1'b1;
    end
  end
endmodule

// File: rtl/hub_hungry_rr.sv
module hub_hungry_rr #(
  parameter int N_CORES = 8,
  parameter int IDX_W   = $clog2(N_CORES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CORES-1:0] cand,
  input  logic               take,
  output logic [N_CORES-1:0] win_oh,
  output logic               any
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CORES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d, win_idx;

  always_comb begin
    win_oh  = '0;
    win_idx = '0;
    any     = 1'b0;
    for (int k = 0; k < N_CORES; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N_CORES) idx = idx - N_CORES;
      if (!any && cand[idx]) begin
        any         = 1'b1;
        win_idx     = IDX_W'(idx);
        win_oh[idx] = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (take && any) ptr_d = (win_idx == LAST) ? '0 : win_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr_q <= '0;
    else if (take && any)      ptr_q <= ptr_d;
  end
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
  import hub_arb_pkg::*;
#(
  parameter  int N_CORES = 8,
  localparam int IDX_W   = $clog2(N_CORES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CORES-1:0]       req_i,
  input  logic [N_CORES-1:0]       hungry_en_i,
  input  logic                     hungry_off_i,
  input  logic [N_CORES*IDX_W-1:0] don_tgt_i,
  input  logic [N_CORES*2-1:0]     don_rate_i,
  input  logic [N_CORES-1:0]       don_sub_i,
  output logic [N_CORES-1:0]       grant_o,
  output logic [1:0]               why_o,
  output logic [IDX_W-1:0]         slot_o
);
  logic [1:0]         occ;
  logic [N_CORES-1:0] pick_oh, win_oh, cand;
  why_e               pick_why;
  logic               spare_stage, any, take;

  hub_slot_seq #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .slot_q(slot_o), .occ(occ)
  );

  hub_slot_claim #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_claim (
    .owner(slot_o), .occ(occ), .req(req_i), .tgt_flat(don_tgt_i),
    .rate_flat(don_rate_i), .sub(don_sub_i), .pick_oh(pick_oh),
    .pick_why(pick_why), .spare_stage(spare_stage)
  );

  assign cand = (spare_stage && !hungry_off_i) ? (req_i & hungry_en_i) : '0;
  assign take = spare_stage && !hungry_off_i;

  hub_hungry_rr #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .cand(cand), .take(take),
    .win_oh(win_oh), .any(any)
  );

  always_comb begin
    if (take && any) begin
      grant_o = win_oh;
      why_o   = WHY_SPARE;
    end else begin
      grant_o = pick_oh;
      why_o   = pick_why;
    end
  end
endmodule

// File: rtl/hub_arb_checker.sv
module hub_arb_checker #(
  parameter  int N_CORES = 8,
  localparam int IDX_W   = $clog2(N_CORES)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_CORES-1:0]       req_i,
  input logic [N_CORES-1:0]       hungry_en_i,
  input logic                     hungry_off_i,
  input logic [N_CORES*IDX_W-1:0] don_tgt_i,
  input logic [N_CORES*2-1:0]     don_rate_i,
  input logic [N_CORES-1:0]       don_sub_i,
  input logic [N_CORES-1:0]       grant_o,
  input logic [1:0]               why_o,
  input logic [IDX_W-1:0]         slot_o
);
  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(slot_o) == IDX_W'(N_CORES - 1)) ? (slot_o == '0)
                                                    : (slot_o == $past(slot_o) + 1'b1));

  p_onehot_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_none_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o == '0) == (why_o == 2'b00));

  p_no_steal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[slot_o] && don_rate_i[int'(slot_o)*2 +: 2] == 2'b00) |-> grant_o[slot_o]);

  p_spare_opt_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (why_o == 2'b11) |-> ((grant_o & ~(req_i & hungry_en_i)) == '0));

  p_hungry_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hungry_off_i |-> (why_o != 2'b11));

  p_donate_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (why_o == 2'b10) |-> grant_o[don_tgt_i[int'(slot_o)*IDX_W +: IDX_W]]);
endmodule

bind hub_slot_arbiter hub_arb_checker #(.N_CORES(N_CORES)) u_chk (.*);

// File: tb/tb_hub_slot_arbiter.sv
`timescale 1ns/100ps
module tb_hub_slot_arbiter;
  localparam int N = 8;

  typedef struct {
    logic [7:0] grant;
    logic [1:0] why;
    logic [2:0] slot;
    string      tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  b_req, b_hen, b_sub;
  logic        b_hoff;
  logic [2:0]  b_tgt [N];
  logic [1:0]  b_rate [N];
  logic [23:0] tgt_flat;
  logic [15:0] rate_flat;
  logic [7:0]  grant;
  logic [1:0]  why;
  logic [2:0]  slot;

  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_slot;
  int m_ord [N];
  int m_ptr;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      tgt_flat[i*3 +: 3]  = b_tgt[i];
      rate_flat[i*2 +: 2] = b_rate[i];
    end
  end

  hub_slot_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_i(b_req), .hungry_en_i(b_hen),
    .hungry_off_i(b_hoff), .don_tgt_i(tgt_flat), .don_rate_i(rate_flat),
    .don_sub_i(b_sub), .grant_o(grant), .why_o(why), .slot_o(slot)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    b_req = '0; b_hen = '0; b_sub = '0; b_hoff = 1'b0;
    for (int i = 0; i < N; i++) begin b_tgt[i] = 3'(i); b_rate[i] = 2'b00; end
  endtask

  // Driver: called at a falling edge; applies inputs, predicts, waits one clock.
  task automatic drive(input string tag);
    item_t it;
    int o, t, r;
    bit forced, first, plain, self_t, spare;
    o = m_slot; t = b_tgt[o]; r = b_rate[o];
    self_t = (t == o);
    forced = !self_t && ((r == 1 && (m_ord[o] % 2 == 1)) || (r == 2 && m_ord[o] != 0));
    first  = forced || (!self_t && r == 3 && b_sub[o]);
    plain  = !self_t && r == 3 && !b_sub[o];
    it.grant = '0; it.why = 2'b00; it.slot = 3'(o); it.tag = tag; spare = 0;
    if (first && b_req[t])      begin it.grant[t] = 1; it.why = 2'b10; end
    else if (b_req[o])          begin it.grant[o] = 1; it.why = 2'b01; end
    else if (plain && b_req[t]) begin it.grant[t] = 1; it.why = 2'b10; end
    else spare = 1;
    if (spare && !b_hoff) begin
      for (int k = 0; k < N; k++) begin
        int idx;
        idx = (m_ptr + k) % N;
        if (it.why == 2'b00 && b_req[idx] && b_hen[idx]) begin
          it.grant[idx] = 1; it.why = 2'b11; m_ptr = (idx + 1) % N;
        end
      end
    end
    exp_q.push_back(it);
    m_ord[o] = (m_ord[o] + 1) % 4;
    m_slot   = (m_slot + 1) % N;
    @(negedge clk);
  endtask

  task automatic run(input string tag, input int n);
    for (int c = 0; c < n; c++) drive(tag);
  endtask

  // Monitor: compares the scoreboard head shortly after each falling edge.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        check({e.tag, " slot"},  32'(slot),  32'(e.slot));
        check({e.tag, " grant"}, 32'(grant), 32'(e.grant));
        check({e.tag, " why"},   32'(why),   32'(e.why));
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_cfg();
    rst_n = 1'b0;
    m_slot = 0; m_ptr = 0;
    for (int i = 0; i < N; i++) m_ord[i] = 0;
    repeat (3) @(negedge clk);
    b_req = 8'hFF;
    #1;
    check("R1 reset slot", 32'(slot), 0);
    check("R3 reset grant", 32'(grant), 32'(8'hFF & 8'h01));
    b_req = '0;
    #1;
    check("R3 reset idle grant", 32'(grant), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: everyone requests, no donation
    b_req = 8'hFF;
    run("R2 owners", 16);
    // R3: nobody requests
    b_req = '0;
    run("R3 idle", 8);
    // R5 R7: hungry 2 and 5 compete, core 6 not opted in
    b_req = 8'b0110_0100; b_hen = 8'b0010_0100;
    run("R7 hungry rr", 16);
    run("R5 opt-in", 8);
    // R6: disable reuse
    b_hoff = 1'b1;
    run("R6 hungry off", 8);
    clear_cfg();
    // R8: plain donation 1 -> 4
    b_rate[1] = 2'b11; b_tgt[1] = 3'd4; b_req = 8'b0001_0000; b_hen = 8'h10;
    run("R8 plain idle owner", 8);
    b_req = 8'b0001_0010;
    run("R4 R8 owner keeps", 8);
    clear_cfg();
    // R9: submissive 3 -> 6
    b_rate[3] = 2'b11; b_tgt[3] = 3'd6; b_sub[3] = 1'b1; b_req = 8'b0100_1000;
    run("R9 submissive both", 8);
    b_req = 8'b0000_1000;
    run("R9 submissive idle tgt", 8);
    clear_cfg();
    // R10: rate 01, 0 -> 7
    b_rate[0] = 2'b01; b_tgt[0] = 3'd7; b_req = 8'b1000_0001;
    run("R10 half rate", 32);
    // R11: rate 10, 2 -> 5
    clear_cfg();
    b_rate[2] = 2'b10; b_tgt[2] = 3'd5; b_req = 8'b0010_0100;
    run("R11 three quarter", 32);
    // R12: forced target idle, owner idle, hungry takes
    b_req = 8'b0000_0100;
    run("R12 tgt idle owner", 16);
    b_req = 8'b0000_0010; b_hen = 8'h02;
    run("R12 fall to hungry", 16);
    clear_cfg();
    b_rate[4] = 2'b11; b_sub[4] = 1'b1; b_tgt[4] = 3'd4; b_req = 8'h10;
    run("R12 self target", 8);
    b_req = '0;
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule